// File: doc/BRIEF.md
# Thermal Sensor Raw-to-Temperature Converter

This block turns one raw 12-bit thermal sensor sample into a signed temperature in millidegrees Celsius. Per-device calibration comes from three 32-bit fuse words, which the block decodes itself. Those words supply an ADC gain error, a reference-temperature code, a signed slope correction and one 9-bit offset for each of six sensing points. A compile-time calibration coefficient completes the set.

A caller presents the fuse words, the raw sample and a sensor code, then pulses `start_i`. The block runs a fixed chain on a sequential divider and a sequential multiplier. A pre-scaled constant is divided by (coefficient + slope) and then by (10000 + gain error). The quotient is multiplied by the offset-corrected sample. The product is shifted right arithmetically by three and subtracted from the reference code times 500. Every input is sampled in the start cycle, and the result is held on `temp_mc_o` until the next conversion completes.

Top module: `therm_conv`

## Requirements
- R1: `start_i` is accepted only while `busy_o` is low, and `busy_o` is high in the cycle after acceptance. A `start_i` raised while busy has no effect on the running conversion, and it does not start a second one.
- R2: `done_o` is a single-cycle pulse. It rises on the same edge on which `busy_o` falls. `temp_mc_o` changes only in a cycle where `done_o` is high and holds its value between conversions.
- R3: The result is `ref*500 - ((((1627604160 / (C + slope)) / (10000 + ge)) * (raw - vts - 3350)) >>> 3)`. Both divisions truncate. When raw equals vts + 3350, the result is exactly ref*500.
- R4: C is the parameter `CALI_COEF`, 165 by default. An instance built with 153 applies that value in the first division.
- R5: When fuse word 0 bit 0 is 0, the fuse fields are ignored. The block then uses gain error 512, reference code 40, slope 0 and offset 260 for every sensor.
- R6: When word 0 bit 0 is 1, the gain error is word1[31:22], the reference code is word0[6:1] and the slope magnitude is word0[31:26].
- R7: The slope is the negated magnitude only when word0[7] and word1[9] are both 1. Otherwise it is the positive magnitude.
- R8: `sensor_sel_i` codes 0 to 5 select the offset fields word0[25:17], word0[16:8], word1[8:0], word2[31:23], word2[13:5] and word2[22:14], in that order. Codes 6 and 7 select the same field as code 0.
- R9: The right shift of the product floors toward minus infinity when the product is negative. This holds across the full raw range 0 to 4095.
- R10: After reset, `busy_o` and `done_o` are 0 and `temp_mc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a conversion when idle |
| raw_i | input | RAW_W | Raw sensor sample |
| sensor_sel_i | input | 3 | Sensing point whose offset applies |
| fuse_w0_i | input | 32 | Calibration fuse word 0 |
| fuse_w1_i | input | 32 | Calibration fuse word 1 |
| fuse_w2_i | input | 32 | Calibration fuse word 2 |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| temp_mc_o | output | TEMP_W | Signed temperature in millidegrees Celsius |

## Verification
The bench builds two instances that share all data inputs. One uses the default coefficient of 165 and the other uses 153, so the same fuse words and sample must give different temperatures that each match the model. That pair is what makes the coefficient requirement testable. Both use the default 12-bit sample and 48-bit datapath, so the extreme samples 0 and 4095 reach the largest positive and negative products the decoded fields allow.

// File: rtl/therm_conv_pkg.sv
package therm_conv_pkg;
  localparam int NUM_TS  = 6;
  localparam int VTS_W   = 9;
  localparam int GE_W    = 10;
  localparam int REF_W   = 6;
  localparam int SLOPE_W = 7;

  typedef struct packed {
    logic [GE_W-1:0]                 gain_err;
    logic [REF_W-1:0]                ref_code;
    logic [SLOPE_W-1:0]              slope;     // two's complement
    logic [NUM_TS-1:0][VTS_W-1:0]    vts;
  } calib_t;

  typedef enum logic [1:0] {ST_IDLE, ST_DIV1, ST_DIV2, ST_MUL} conv_st_e;
endpackage

// File: rtl/therm_fuse_unpack.sv
module therm_fuse_unpack
  import therm_conv_pkg::*;
#(
  parameter int DEF_GE    = 512,
  parameter int DEF_REF   = 40,
  parameter int DEF_SLOPE = 0,
  parameter int DEF_VTS   = 260
) (
  input  logic [31:0] word0_i,
  input  logic [31:0] word1_i,
  input  logic [31:0] word2_i,
  output calib_t      cal_o
);
  logic                          valid;
  logic                          slope_neg;
  logic [SLOPE_W-1:0]            mag_ext;
  logic [NUM_TS-1:0][VTS_W-1:0]  fuse_vts;
  logic [NUM_TS-1:0][VTS_W-1:0]  vts_sel;
  logic                          unused_bits;

  assign valid     = word0_i[0];
  assign slope_neg = word1_i[9] & word0_i[7];
  assign mag_ext   = {1'b0, word0_i[31:26]};

  // sensor order is the select encoding seen at the top
  assign fuse_vts[0] = word0_i[25:17];
  assign fuse_vts[1] = word0_i[16:8];
  assign fuse_vts[2] = word1_i[8:0];
  assign fuse_vts[3] = word2_i[31:23];
  assign fuse_vts[4] = word2_i[13:5];
  assign fuse_vts[5] = word2_i[22:14];

  for (genvar g = 0; g < NUM_TS; g++) begin : g_vts
    assign vts_sel[g] = valid ? fuse_vts[g] : VTS_W'(DEF_VTS);
  end

  always_comb begin
    cal_o.vts = vts_sel;
    if (valid) begin
      cal_o.gain_err = word1_i[31:22];
      cal_o.ref_code = word0_i[6:1];
      cal_o.slope    = slope_neg ? (~mag_ext + 1'b1) : mag_ext;
    end else begin
      cal_o.gain_err = GE_W'(DEF_GE);
      cal_o.ref_code = REF_W'(DEF_REF);
      cal_o.slope    = SLOPE_W'(DEF_SLOPE);
    end
  end

  assign unused_bits = ^{word1_i[21:10], word2_i[4:0]};
endmodule

// File: rtl/therm_seq_div.sv
module therm_seq_div #(
  parameter int NUM_W = 32,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] quo_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;
  logic [DEN_W:0]   rem_sh, rem_sub;
  logic             fits;
  logic             unused_sub;

  assign rem_sh     = {rem_q, quo_q[NUM_W-1]};
  assign rem_sub    = rem_sh - {1'b0, den_q};
  assign fits       = rem_sh >= {1'b0, den_q};
  assign unused_sub = rem_sub[DEN_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        quo_q <= {quo_q[NUM_W-2:0], fits};
        rem_q <= fits ? rem_sub[DEN_W-1:0] : rem_sh[DEN_W-1:0];
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        quo_q  <= num_i;
        rem_q  <= '0;
        den_q  <= den_i;
        cnt_q  <= CNT_W'(NUM_W);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign quo_o  = quo_q;
endmodule

// File: rtl/therm_seq_mul.sv
module therm_seq_mul #(
  parameter int A_W = 32,
  parameter int B_W = 13
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [A_W-1:0]     a_i,
  input  logic [B_W-1:0]     b_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [A_W+B_W-1:0] prod_o
);
  localparam int P_W   = A_W + B_W;
  localparam int CNT_W = $clog2(B_W + 1);

  logic [P_W-1:0]   acc_q, a_q;
  logic [B_W-1:0]   b_q;
  logic [CNT_W-1:0] cnt_q;
  logic             busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      a_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy_q) begin
        if (b_q[0]) acc_q <= acc_q + a_q;
        a_q   <= a_q << 1;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q - CNT_W'(1);
        if (cnt_q == CNT_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (start_i) begin
        acc_q  <= '0;
        a_q    <= P_W'(a_i);
        b_q    <= b_i;
        cnt_q  <= CNT_W'(B_W);
        busy_q <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign prod_o = acc_q;
endmodule

// File: rtl/therm_conv.sv
module therm_conv
  import therm_conv_pkg::*;
#(
  parameter int CALI_COEF = 165,
  parameter int RAW_W     = 12,
  parameter int DP_W      = 48,
  parameter int TEMP_W    = 32,
  parameter int DEF_GE    = 512,
  parameter int DEF_REF   = 40,
  parameter int DEF_SLOPE = 0,
  parameter int DEF_VTS   = 260
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [RAW_W-1:0]         raw_i,
  input  logic [2:0]               sensor_sel_i,
  input  logic [31:0]              fuse_w0_i,
  input  logic [31:0]              fuse_w1_i,
  input  logic [31:0]              fuse_w2_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic signed [TEMP_W-1:0] temp_mc_o
);
  localparam int     NUM_W       = 32;
  localparam int     DEN_W       = 16;
  localparam int     MAG_W       = RAW_W + 1;
  localparam int     P_W         = NUM_W + MAG_W;
  localparam longint SCALE_BASE  = 64'd203450520;
  localparam logic [NUM_W-1:0] SCALED_K = NUM_W'(SCALE_BASE * 8);
  localparam int     GE_BASE     = 10000;
  localparam int     DIFF_OFFS   = 3350;
  localparam int     MC_PER_CODE = 500;

  calib_t              cal;
  conv_st_e            state_q;
  logic [GE_W-1:0]     gain_q;
  logic [REF_W-1:0]    ref_q;
  logic                diff_neg_q;
  logic [MAG_W-1:0]    diff_mag_q;
  logic signed [TEMP_W-1:0] temp_q;
  logic                done_q;

  logic [VTS_W-1:0]    vts_pick;
  logic signed [DP_W-1:0] diff_s, diff_abs;
  logic [DEN_W-1:0]    den1, den2;

  logic                div_start, div_busy, div_done;
  logic [NUM_W-1:0]    div_num, div_quo;
  logic [DEN_W-1:0]    div_den;
  logic                mul_start, mul_busy, mul_done;
  logic [P_W-1:0]      mul_prod;

  logic signed [DP_W-1:0] prod_s, prod_sh, ref_mc, res_s;
  logic                unused_sig;

  therm_fuse_unpack #(
    .DEF_GE(DEF_GE), .DEF_REF(DEF_REF), .DEF_SLOPE(DEF_SLOPE), .DEF_VTS(DEF_VTS)
  ) u_unpack (
    .word0_i(fuse_w0_i),
    .word1_i(fuse_w1_i),
    .word2_i(fuse_w2_i),
    .cal_o  (cal)
  );

  // out-of-range codes fall back to the first sensing point
  assign vts_pick = (sensor_sel_i < 3'(NUM_TS)) ? cal.vts[sensor_sel_i] : cal.vts[0];
  assign diff_s   = $signed(DP_W'(raw_i)) - $signed(DP_W'(vts_pick)) - $signed(DP_W'(DIFF_OFFS));
  assign diff_abs = diff_s[DP_W-1] ? -diff_s : diff_s;

  assign den1 = DEN_W'(CALI_COEF) + {{(DEN_W-SLOPE_W){cal.slope[SLOPE_W-1]}}, cal.slope};
  assign den2 = DEN_W'(GE_BASE) + DEN_W'(gain_q);

  assign div_start = ((state_q == ST_IDLE) && start_i) || ((state_q == ST_DIV1) && div_done);
  assign div_num   = (state_q == ST_IDLE) ? SCALED_K : div_quo;
  assign div_den   = (state_q == ST_IDLE) ? den1 : den2;
  assign mul_start = (state_q == ST_DIV2) && div_done;

  therm_seq_div #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  therm_seq_mul #(.A_W(NUM_W), .B_W(MAG_W)) u_mul (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(mul_start),
    .a_i    (div_quo),
    .b_i    (diff_mag_q),
    .busy_o (mul_busy),
    .done_o (mul_done),
    .prod_o (mul_prod)
  );

  assign prod_s  = diff_neg_q ? -$signed(DP_W'(mul_prod)) : $signed(DP_W'(mul_prod));
  assign prod_sh = prod_s >>> 3;
  assign ref_mc  = $signed(DP_W'(ref_q) * DP_W'(MC_PER_CODE));
  assign res_s   = ref_mc - prod_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      gain_q     <= '0;
      ref_q      <= '0;
      diff_neg_q <= 1'b0;
      diff_mag_q <= '0;
      temp_q     <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          gain_q     <= cal.gain_err;
          ref_q      <= cal.ref_code;
          diff_neg_q <= diff_s[DP_W-1];
          diff_mag_q <= diff_abs[MAG_W-1:0];
          state_q    <= ST_DIV1;
        end
        ST_DIV1: if (div_done) state_q <= ST_DIV2;
        ST_DIV2: if (div_done) state_q <= ST_MUL;
        ST_MUL:  if (mul_done) begin
          temp_q  <= res_s[TEMP_W-1:0];
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign unused_sig = ^{div_busy, mul_busy, diff_abs[DP_W-1:MAG_W], res_s[DP_W-1:TEMP_W]};

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign temp_mc_o = temp_q;
endmodule

// File: rtl/therm_conv_chk.sv
module therm_conv_chk #(
  parameter int TEMP_W = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic signed [TEMP_W-1:0] temp_mc_o
);
  // R1
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  // R1
  busy_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R2
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R2
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  // R2
  temp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(temp_mc_o));
endmodule

bind therm_conv therm_conv_chk #(.TEMP_W(TEMP_W)) u_chk (.*);

// File: tb/therm_conv_bench.sv
module therm_conv_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_a = 1'b0, start_b = 1'b0;
  logic [11:0] raw = '0;
  logic [2:0]  sel = '0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0;
  logic        busy_a, done_a, busy_b, done_b;
  logic signed [31:0] temp_a, temp_b;

  int checks = 0;
  int fails  = 0;
  int f_valid, f_ge, f_ref, f_mag, f_sign, f_id;
  int f_vts[6];

  therm_conv u_therm_conv (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_a), .raw_i(raw), .sensor_sel_i(sel),
    .fuse_w0_i(w0), .fuse_w1_i(w1), .fuse_w2_i(w2),
    .busy_o(busy_a), .done_o(done_a), .temp_mc_o(temp_a)
  );

  therm_conv #(.CALI_COEF(153)) u_therm_conv_alt (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_b), .raw_i(raw), .sensor_sel_i(sel),
    .fuse_w0_i(w0), .fuse_w1_i(w1), .fuse_w2_i(w2),
    .busy_o(busy_b), .done_o(done_b), .temp_mc_o(temp_b)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cal(input int valid, input int ge, input int rc, input int mag,
                         input int sgn, input int id);
    f_valid = valid; f_ge = ge; f_ref = rc; f_mag = mag; f_sign = sgn; f_id = id;
  endtask

  task automatic pack_words();
    w0 = (32'(f_mag) << 26) | (32'(f_vts[0]) << 17) | (32'(f_vts[1]) << 8) |
         (32'(f_sign) << 7) | (32'(f_ref) << 1) | 32'(f_valid);
    w1 = (32'(f_ge) << 22) | (32'(f_id) << 9) | 32'(f_vts[2]);
    w2 = (32'(f_vts[3]) << 23) | (32'(f_vts[5]) << 14) | (32'(f_vts[4]) << 5);
  endtask

  function automatic longint model(input int cali, input int s_raw, input int s_sel);
    longint t;
    int ge, rc, slope, vts;
    if (f_valid == 0) begin
      ge = 512; rc = 40; slope = 0; vts = 260;
    end else begin
      ge = f_ge; rc = f_ref;
      slope = (f_id == 1 && f_sign == 1) ? -f_mag : f_mag;
      vts = (s_sel < 6) ? f_vts[s_sel] : f_vts[0];
    end
    t = longint'(203450520) * 8;
    t = t / longint'(cali + slope);
    t = t / longint'(10000 + ge);
    t = t * longint'(s_raw - vts - 3350);
    t = t >>> 3;
    return longint'(rc) * 500 - t;
  endfunction

  task automatic wait_done(input bit alt, output bit seen);
    seen = 1'b0;
    for (int n = 0; n < 1000; n++) begin
      if ((alt ? done_b : done_a) == 1'b1) begin
        seen = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic run_conv(input bit alt, input int r, input int s, input string req);
    longint exp;
    bit seen;
    exp = model(alt ? 153 : 165, r, s);
    @(negedge clk);
    pack_words();
    raw = 12'(r);
    sel = 3'(s);
    if (alt) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    start_b = 1'b0;
    chk((alt ? busy_b : busy_a) == 1'b1, "R1 busy after start", longint'(alt ? busy_b : busy_a), 1);
    wait_done(alt, seen);
    chk(seen, "R2 done seen", longint'(seen), 1);
    chk(longint'(alt ? temp_b : temp_a) == exp, req, longint'(alt ? temp_b : temp_a), exp);
    @(negedge clk);
    chk((alt ? done_b : done_a) == 1'b0, "R2 done single cycle", longint'(alt ? done_b : done_a), 0);
  endtask

  task automatic t_reset();
    chk(busy_a == 1'b0 && busy_b == 1'b0, "R10 busy at reset", longint'(busy_a | busy_b), 0);
    chk(done_a == 1'b0 && done_b == 1'b0, "R10 done at reset", longint'(done_a | done_b), 0);
    chk(temp_a == 0 && temp_b == 0, "R10 temp at reset", longint'(temp_a), 0);
  endtask

  task automatic t_defaults();
    f_vts = '{11, 22, 33, 44, 55, 66};
    set_cal(0, 1000, 10, 50, 1, 1);
    run_conv(1'b0, 2500, 0, "R5 defaults raw 2500");
    run_conv(1'b0, 3900, 4, "R5 defaults raw 3900");
  endtask

  task automatic t_fields();
    f_vts = '{120, 250, 330, 410, 77, 500};
    set_cal(1, 300, 35, 20, 0, 1);
    run_conv(1'b0, 3000, 1, "R6 fields positive slope");
    set_cal(1, 1023, 63, 63, 1, 0);
    run_conv(1'b0, 3700, 3, "R6 max fields");
  endtask

  task automatic t_slope_sign();
    f_vts = '{200, 210, 220, 230, 240, 250};
    set_cal(1, 100, 30, 40, 1, 1);
    run_conv(1'b0, 3400, 2, "R7 negative slope");
    set_cal(1, 100, 30, 40, 1, 0);
    run_conv(1'b0, 3400, 2, "R7 sign without id");
    set_cal(1, 100, 30, 40, 0, 1);
    run_conv(1'b0, 3400, 2, "R7 id without sign");
  endtask

  task automatic t_sensors();
    f_vts = '{10, 100, 200, 300, 400, 511};
    set_cal(1, 512, 40, 5, 0, 0);
    for (int s = 0; s < 8; s++) run_conv(1'b0, 3600, s, "R8 sensor select");
  endtask

  task automatic t_extremes();
    f_vts = '{260, 17, 300, 1, 2, 3};
    set_cal(1, 250, 45, 30, 1, 1);
    run_conv(1'b0, 0, 0, "R9 raw zero");
    run_conv(1'b0, 4095, 1, "R9 raw full scale");
    run_conv(1'b0, 3601, 0, "R9 small negative product");
    run_conv(1'b0, 3610, 0, "R3 zero offset term");
    chk(temp_a == 45 * 500, "R3 ref times 500", longint'(temp_a), 45 * 500);
  endtask

  task automatic t_busy_ignore();
    longint exp;
    bit seen;
    int extra;
    f_vts = '{150, 160, 170, 180, 190, 200};
    set_cal(1, 400, 38, 12, 0, 0);
    exp = model(165, 1000, 2);
    @(negedge clk);
    pack_words();
    raw = 12'd1000; sel = 3'd2; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    repeat (5) @(negedge clk);
    raw = 12'd4000; sel = 3'd5; start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0;
    wait_done(1'b0, seen);
    chk(seen && longint'(temp_a) == exp, "R1 start while busy ignored", longint'(temp_a), exp);
    extra = 0;
    for (int n = 0; n < 120; n++) begin
      @(negedge clk);
      if (done_a || busy_a) extra++;
      if (longint'(temp_a) != exp) extra++;
    end
    chk(extra == 0, "R2 result held, no second run", extra, 0);
  endtask

  task automatic t_alt_coef();
    f_vts = '{230, 240, 250, 260, 270, 280};
    set_cal(1, 600, 50, 10, 0, 0);
    run_conv(1'b1, 2800, 3, "R4 coefficient 153");
    run_conv(1'b0, 2800, 3, "R4 coefficient 165");
    chk(temp_a != temp_b, "R4 coefficients differ", longint'(temp_b), longint'(temp_a));
    set_cal(0, 0, 0, 0, 0, 0);
    run_conv(1'b1, 1500, 0, "R4 coefficient 153 defaults");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_defaults();
    t_fields();
    t_slope_sign();
    t_sensors();
    t_extremes();
    t_busy_ignore();
    t_alt_coef();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule